// File: doc/BRIEF.md
# Block Transfer Sequencer

This block runs a repeated read transfer from one module slot of a crate bus after a setup command has been accepted. A start strobe presents the target slot, subaddress and function, a word count and a no-Q limit, both coded as value minus one. The sequencer then issues read cycles to that target, keeping a minimum spacing between cycle starts. Each read that answers with Q becomes a typed data frame for the serial transmitter. A read without Q only uses up the no-Q allowance.

A transfer ends in one of four ways: the word count runs out, the no-Q allowance runs out, no Q arrives within a timeout window, or a stop strobe arrives. A status frame is sent when the transfer starts and another when it ends. The end frame reports which of the three counted causes ended it, and reports none when a stop strobe ended it. While a transfer runs, the block raises an active flag and shows the target slot. On acceptance it sends a one-cycle pulse that clears the host port's slot reservation.

Top module: `blkxfer_seq`

## Requirements
- R1: A start strobe with setupN greater than 23 or setupF greater than 7 is rejected. The block stays inactive, emits no frame and issues no cycle.
- R2: An accepted start sets active, drives slotOut to setupN, and emits one status frame in the next cycle. A status frame has bits 25:24 = 2'b10, bits 23:16 = crateAddr, bits 12:8 = slot, bit 3 = transfer-active, bits 2:0 = end cause, and all other bits zero. In the start frame bit 3 is 1 and bits 2:0 are 0.
- R3: clrSlotRes pulses for exactly one cycle, in the cycle in which active rises.
- R4: cycReq carries the latched N, A and F, stays high until cycDone is seen, and rises no more often than once every GAP_CYC clock cycles.
- R5: Each completion with cycQ high emits one data frame: bits 25:24 = 2'b11 and bits 23:0 = cycData. A completion with cycQ low emits no frame.
- R6: A word count field W yields exactly W+1 data frames. The end frame that follows has bit 2 set.
- R7: A no-Q field M ends the transfer on the (M+1)th no-Q completion. Q completions in between do not restore the allowance. The end frame has bit 1 set.
- R8: If TO_CYC cycles pass without a Q completion, the transfer ends with bit 0 set in the end frame. The timer restarts on every Q completion.
- R9: A stop strobe during a transfer ends it with end frame bits 2:0 = 0. A stop strobe while idle has no effect.
- R10: The end frame has bit 3 = 0 and at most one of bits 2:0 set. Active falls in the cycle it appears, and slotOut reads zero whenever active is low.
- R11: A start strobe during a transfer is ignored: no new frame is sent and the slot is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | Setup command strobe |
| stopStb | input | 1 | Stop command strobe |
| setupN | input | 5 | Target slot |
| setupA | input | 4 | Target subaddress |
| setupF | input | 5 | Target function |
| wcField | input | 16 | Word count minus one |
| nqField | input | 8 | No-Q limit minus one |
| crateAddr | input | 8 | Crate address placed in status frames |
| cycDone | input | 1 | Bus cycle complete |
| cycQ | input | 1 | Q response of the completed cycle |
| cycData | input | 24 | Read data of the completed cycle |
| cycReq | output | 1 | Read cycle request |
| cycN | output | 5 | Slot for the requested cycle |
| cycA | output | 4 | Subaddress for the requested cycle |
| cycF | output | 5 | Function for the requested cycle |
| frameValid | output | 1 | One-cycle frame strobe |
| frameWord | output | 26 | Header (2 bits) and 24-bit payload |
| active | output | 1 | Transfer in progress |
| slotOut | output | 5 | Target slot, zero when inactive |
| clrSlotRes | output | 1 | Pulse that clears the host slot reservation |

## Verification
The transfer is driven with four kinds of responder pattern: all-Q replies, which separate word-count termination from the other causes; mixed no-Q and Q replies, which show that Q does not restore the no-Q allowance; slow Q replies whose total time exceeds the timeout while each gap stays inside it, which show the timer restart; and a silent responder, which shows a real timeout. A stop strobe in the middle of a run, and strobes given while idle or already running, cover the silent stop and the ignored commands. Out-of-range slot and function values cover setup rejection. The spacing between cycle requests is measured throughout all of these runs.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  localparam int SLOT_W = 5;
  localparam int SUBADDR_W = 4;
  localparam int FUNC_W = 5;
  localparam int WCNT_W = 16;
  localparam int NOQ_W = 8;
  localparam int DATA_W = 24;
  localparam int CRATE_W = 8;
  localparam int HDR_W = 2;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int SLOT_LIMIT = 24;
  localparam int READ_FUNC_LIMIT = 8;
  localparam logic [HDR_W-1:0] HDR_STATUS = 2'b10;
  localparam logic [HDR_W-1:0] HDR_DATA = 2'b11;

  typedef enum logic [1:0] {
    END_CMD,
    END_WCNT,
    END_NOQ,
    END_TIMEOUT
  } endCause_t;

  typedef struct packed {
    logic load;
    logic issue;
    logic takeQ;
    logic takeNoQ;
    logic finish;
    endCause_t cause;
  } ctrlStb_t;

  typedef struct packed {
    logic wcZero;
    logic nqZero;
    logic gapDone;
    logic timeUp;
  } dpFlags_t;
endpackage

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startStb,
  input  logic               stopStb,
  input  logic [SLOT_W-1:0]  setupN,
  input  logic [FUNC_W-1:0]  setupF,
  input  logic               cycDone,
  input  logic               cycQ,
  input  dpFlags_t           flags,
  output ctrlStb_t           stb
);
  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_BUSY, ST_FINISH} state_t;

  state_t state, nxtState;
  endCause_t causeReg, nxtCause;
  logic setupOk;

  assign setupOk = (setupN < SLOT_W'(SLOT_LIMIT)) && (setupF < FUNC_W'(READ_FUNC_LIMIT));

  always_comb begin
    stb = '0;
    stb.cause = causeReg;
    nxtState = state;
    nxtCause = causeReg;
    unique case (state)
      ST_IDLE: begin
        if (startStb && setupOk) begin
          stb.load = 1'b1;
          nxtState = ST_GAP;
        end
      end
      ST_GAP: begin
        if (stopStb) begin
          nxtCause = END_CMD;
          nxtState = ST_FINISH;
        end else if (flags.timeUp) begin
          nxtCause = END_TIMEOUT;
          nxtState = ST_FINISH;
        end else if (flags.gapDone) begin
          stb.issue = 1'b1;
          nxtState = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (stopStb) begin
          nxtCause = END_CMD;
          nxtState = ST_FINISH;
        end else if (cycDone) begin
          if (cycQ) begin
            stb.takeQ = 1'b1;
            if (flags.wcZero) begin
              nxtCause = END_WCNT;
              nxtState = ST_FINISH;
            end else begin
              nxtState = ST_GAP;
            end
          end else begin
            stb.takeNoQ = 1'b1;
            if (flags.nqZero) begin
              nxtCause = END_NOQ;
              nxtState = ST_FINISH;
            end else begin
              nxtState = ST_GAP;
            end
          end
        end else if (flags.timeUp) begin
          nxtCause = END_TIMEOUT;
          nxtState = ST_FINISH;
        end
      end
      ST_FINISH: begin
        stb.finish = 1'b1;
        nxtState = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      causeReg <= END_CMD;
    end else begin
      state <= nxtState;
      causeReg <= nxtCause;
    end
  end
endmodule

// File: rtl/blkxfer_dp.sv
module blkxfer_dp
  import blkxfer_pkg::*;
#(
  parameter int GAP_CYC = 1000,
  parameter int TO_CYC = 125_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStb_t             stb,
  input  logic [SLOT_W-1:0]    setupN,
  input  logic [SUBADDR_W-1:0] setupA,
  input  logic [FUNC_W-1:0]    setupF,
  input  logic [WCNT_W-1:0]    wcField,
  input  logic [NOQ_W-1:0]     nqField,
  input  logic [CRATE_W-1:0]   crateAddr,
  input  logic [DATA_W-1:0]    cycData,
  output dpFlags_t             flags,
  output logic                 cycReq,
  output logic [SLOT_W-1:0]    cycN,
  output logic [SUBADDR_W-1:0] cycA,
  output logic [FUNC_W-1:0]    cycF,
  output logic                 frameValid,
  output logic [FRAME_W-1:0]   frameWord,
  output logic                 active,
  output logic [SLOT_W-1:0]    slotOut,
  output logic                 clrSlotRes
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam int TO_W = $clog2(TO_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TO_CYC - 1);

  logic [WCNT_W-1:0] wcCnt;
  logic [NOQ_W-1:0]  nqCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [TO_W-1:0]   toCnt;

  function automatic logic [2:0] causeBits(endCause_t c);
    case (c)
      END_WCNT:    return 3'b100;
      END_NOQ:     return 3'b010;
      END_TIMEOUT: return 3'b001;
      default:     return 3'b000;
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] statusWord(logic [CRATE_W-1:0] crate,
                                                    logic [SLOT_W-1:0] slot,
                                                    logic bta, logic [2:0] bits);
    return {HDR_STATUS, crate, 3'b000, slot, 4'b0000, bta, bits};
  endfunction

  assign flags.wcZero  = (wcCnt == '0);
  assign flags.nqZero  = (nqCnt == '0);
  assign flags.gapDone = (gapCnt == GAP_LAST);
  assign flags.timeUp  = (toCnt == TO_LAST);
  assign slotOut = active ? cycN : '0;

  // target and counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycN <= '0;
      cycA <= '0;
      cycF <= '0;
      wcCnt <= '0;
      nqCnt <= '0;
    end else if (stb.load) begin
      cycN <= setupN;
      cycA <= setupA;
      cycF <= setupF;
      wcCnt <= wcField;
      nqCnt <= nqField;
    end else begin
      if (stb.takeQ && !flags.wcZero) wcCnt <= wcCnt - 1'b1;
      if (stb.takeNoQ && !flags.nqZero) nqCnt <= nqCnt - 1'b1;
    end
  end

  // cycle spacing and response timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt <= '0;
      toCnt <= '0;
    end else begin
      if (stb.load || stb.issue) gapCnt <= '0;
      else if (gapCnt != GAP_LAST) gapCnt <= gapCnt + 1'b1;
      if (stb.load || stb.takeQ) toCnt <= '0;
      else if (active && toCnt != TO_LAST) toCnt <= toCnt + 1'b1;
    end
  end

  // request, frames and activity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycReq <= 1'b0;
      frameValid <= 1'b0;
      frameWord <= '0;
      active <= 1'b0;
      clrSlotRes <= 1'b0;
    end else begin
      clrSlotRes <= stb.load;
      frameValid <= 1'b0;
      if (stb.issue) cycReq <= 1'b1;
      else if (stb.takeQ || stb.takeNoQ || stb.finish) cycReq <= 1'b0;
      if (stb.load) begin
        active <= 1'b1;
        frameValid <= 1'b1;
        frameWord <= statusWord(crateAddr, setupN, 1'b1, 3'b000);
      end else if (stb.takeQ) begin
        frameValid <= 1'b1;
        frameWord <= {HDR_DATA, cycData};
      end else if (stb.finish) begin
        active <= 1'b0;
        frameValid <= 1'b1;
        frameWord <= statusWord(crateAddr, cycN, 1'b0, causeBits(stb.cause));
      end
    end
  end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int GAP_CYC = 1000,
  parameter int TO_CYC = 125_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 startStb,
  input  logic                 stopStb,
  input  logic [SLOT_W-1:0]    setupN,
  input  logic [SUBADDR_W-1:0] setupA,
  input  logic [FUNC_W-1:0]    setupF,
  input  logic [WCNT_W-1:0]    wcField,
  input  logic [NOQ_W-1:0]     nqField,
  input  logic [CRATE_W-1:0]   crateAddr,
  input  logic                 cycDone,
  input  logic                 cycQ,
  input  logic [DATA_W-1:0]    cycData,
  output logic                 cycReq,
  output logic [SLOT_W-1:0]    cycN,
  output logic [SUBADDR_W-1:0] cycA,
  output logic [FUNC_W-1:0]    cycF,
  output logic                 frameValid,
  output logic [FRAME_W-1:0]   frameWord,
  output logic                 active,
  output logic [SLOT_W-1:0]    slotOut,
  output logic                 clrSlotRes
);
  ctrlStb_t stb;
  dpFlags_t flags;

  blkxfer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .stopStb(stopStb),
    .setupN(setupN), .setupF(setupF), .cycDone(cycDone), .cycQ(cycQ),
    .flags(flags), .stb(stb)
  );

  blkxfer_dp #(.GAP_CYC(GAP_CYC), .TO_CYC(TO_CYC)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .setupN(setupN), .setupA(setupA),
    .setupF(setupF), .wcField(wcField), .nqField(nqField), .crateAddr(crateAddr),
    .cycData(cycData), .flags(flags), .cycReq(cycReq), .cycN(cycN), .cycA(cycA),
    .cycF(cycF), .frameValid(frameValid), .frameWord(frameWord), .active(active),
    .slotOut(slotOut), .clrSlotRes(clrSlotRes)
  );
endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        active,
  input logic [4:0]  slotOut,
  input logic        cycReq,
  input logic        cycDone,
  input logic        cycQ,
  input logic        frameValid,
  input logic [25:0] frameWord,
  input logic        clrSlotRes
);
  // R10
  slot_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> slotOut == 5'd0);

  // R4
  req_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycReq |-> active);

  // R2
  start_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> frameValid && frameWord[25:24] == 2'b10 && frameWord[3] && frameWord[2:0] == 3'b000);

  // R3
  clr_res_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> clrSlotRes);

  // R3
  clr_res_only_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clrSlotRes |-> $rose(active));

  // R10
  end_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> frameValid && frameWord[25:24] == 2'b10 && !frameWord[3] && $countones(frameWord[2:0]) <= 1);

  // R5
  data_frame_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameValid && frameWord[25:24] == 2'b11) |-> $past(cycDone && cycQ && cycReq));
endmodule

bind blkxfer_seq blkxfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .slotOut(slotOut), .cycReq(cycReq),
  .cycDone(cycDone), .cycQ(cycQ), .frameValid(frameValid), .frameWord(frameWord),
  .clrSlotRes(clrSlotRes)
);

// File: tb/blkxfer_seq_test.sv
`timescale 1ns/1ps
module blkxfer_seq_test;
  localparam int GAP = 8;
  localparam int TOUT = 60;
  localparam logic [7:0] CRATE = 8'h5C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startStb = 0, stopStb = 0, cycDone = 0, cycQ = 0;
  logic [4:0] setupN = 0, setupF = 0;
  logic [3:0] setupA = 0;
  logic [15:0] wcField = 0;
  logic [7:0] nqField = 0;
  logic [23:0] cycData = 0;
  logic cycReq, frameValid, active, clrSlotRes;
  logic [4:0] cycN, cycF, slotOut;
  logic [3:0] cycA;
  logic [25:0] frameWord;

  int checks = 0, errors = 0;
  logic [25:0] flog [0:63];
  int fcnt = 0, reqCnt = 0, cyc = 0, lastRise = -1, minGap = 1000000;
  logic prevReq = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  blkxfer_seq #(.GAP_CYC(GAP), .TO_CYC(TOUT)) uut (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .stopStb(stopStb),
    .setupN(setupN), .setupA(setupA), .setupF(setupF), .wcField(wcField),
    .nqField(nqField), .crateAddr(CRATE), .cycDone(cycDone), .cycQ(cycQ),
    .cycData(cycData), .cycReq(cycReq), .cycN(cycN), .cycA(cycA), .cycF(cycF),
    .frameValid(frameValid), .frameWord(frameWord), .active(active),
    .slotOut(slotOut), .clrSlotRes(clrSlotRes)
  );

  always @(negedge clk) begin
    cyc++;
    if (frameValid && fcnt < 64) begin
      flog[fcnt] = frameWord;
      fcnt++;
    end
    if (cycReq && !prevReq) begin
      reqCnt++;
      if (lastRise >= 0 && cyc - lastRise < minGap) minGap = cyc - lastRise;
      lastRise = cyc;
    end
    prevReq = cycReq;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] statusFrame(logic [4:0] n, logic bta, logic [2:0] bits);
    return {2'b10, CRATE, 3'b000, n, 4'b0000, bta, bits};
  endfunction

  task automatic doStart(logic [4:0] n, logic [3:0] a, logic [4:0] f, logic [15:0] wc, logic [7:0] nq);
    @(negedge clk);
    setupN = n; setupA = a; setupF = f; wcField = wc; nqField = nq; startStb = 1;
    @(negedge clk);
    startStb = 0;
  endtask

  task automatic waitReq();
    for (int i = 0; i < 500 && !cycReq; i++) @(negedge clk);
  endtask

  task automatic respond(logic q, logic [23:0] d, int dly);
    waitReq();
    repeat (dly) @(negedge clk);
    cycQ = q; cycData = d; cycDone = 1;
    @(negedge clk);
    cycDone = 0; cycQ = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000 && active; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    check("R10 reset active", active, 0);
    check("R10 reset slotOut", slotOut, 0);
    check("R4 reset cycReq", cycReq, 0);
    check("R2 reset frameValid", frameValid, 0);
  endtask

  task automatic tReject();
    int fb = fcnt, rb = reqCnt;
    doStart(5'd24, 0, 0, 3, 3);
    repeat (4) @(negedge clk);
    check("R1 slot 24 inactive", active, 0);
    doStart(5'd3, 0, 5'd8, 3, 3);
    repeat (GAP + 4) @(negedge clk);
    check("R1 function 8 inactive", active, 0);
    check("R1 no frames", fcnt - fb, 0);
    check("R1 no cycles", reqCnt - rb, 0);
  endtask

  task automatic tWordCount();
    int fb = fcnt;
    doStart(5'd5, 4'd2, 5'd1, 16'd2, 8'd3);
    check("R2 active after start", active, 1);
    check("R2 slotOut", slotOut, 5);
    check("R3 clrSlotRes pulse", clrSlotRes, 1);
    @(negedge clk);
    check("R3 clrSlotRes single", clrSlotRes, 0);
    waitReq();
    check("R4 cycle target", {cycN, cycA, cycF}, {5'd5, 4'd2, 5'd1});
    repeat (3) @(negedge clk);
    check("R4 request held", cycReq, 1);
    for (int i = 0; i < 3; i++) respond(1, 24'hA00001 + i, 1);
    waitIdle();
    check("R6 frame count", fcnt - fb, 5);
    check("R2 start frame", flog[fb], statusFrame(5, 1, 3'b000));
    for (int i = 0; i < 3; i++)
      check("R5 data frame", flog[fb + 1 + i], {2'b11, 24'hA00001 + 24'(i)});
    check("R6 end frame", flog[fb + 4], statusFrame(5, 0, 3'b100));
    check("R10 slot zero after end", slotOut, 0);
    check("R4 no request after end", cycReq, 0);
  endtask

  task automatic tNoQ();
    int fb = fcnt, rb = reqCnt;
    doStart(5'd7, 4'd1, 5'd3, 16'd10, 8'd1);
    respond(0, 24'h111111, 0);
    respond(1, 24'h222222, 0);
    respond(0, 24'h333333, 0);
    waitIdle();
    check("R7 cycles issued", reqCnt - rb, 3);
    check("R7 frame count", fcnt - fb, 3);
    check("R5 only Q frame", flog[fb + 1], {2'b11, 24'h222222});
    check("R7 end frame", flog[fb + 2], statusFrame(7, 0, 3'b010));
  endtask

  task automatic tTimeout();
    int fb = fcnt;
    doStart(5'd12, 4'd0, 5'd0, 16'd10, 8'd10);
    for (int i = 0; i < 3; i++) respond(1, 24'h0000C0 + 24'(i), 40);
    check("R8 still active after slow Q replies", active, 1);
    waitIdle();
    check("R8 frame count", fcnt - fb, 5);
    check("R8 end frame", flog[fb + 4], statusFrame(12, 0, 3'b001));
    check("R4 request dropped", cycReq, 0);
  endtask

  task automatic tStop();
    int fb = fcnt;
    doStart(5'd20, 4'd15, 5'd2, 16'd10, 8'd10);
    respond(1, 24'hBEEF01, 0);
    waitReq();
    setupN = 5'd2; startStb = 1;
    @(negedge clk);
    startStb = 0;
    @(negedge clk);
    check("R11 slot unchanged", slotOut, 20);
    check("R11 no extra frame", fcnt - fb, 2);
    stopStb = 1;
    @(negedge clk);
    stopStb = 0;
    waitIdle();
    check("R9 frame count", fcnt - fb, 3);
    check("R9 end frame silent", flog[fb + 2], statusFrame(20, 0, 3'b000));
    check("R9 inactive", active, 0);
    fb = fcnt;
    stopStb = 1;
    @(negedge clk);
    stopStb = 0;
    repeat (3) @(negedge clk);
    check("R9 idle stop no frame", fcnt - fb, 0);
    check("R9 idle stop inactive", active, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1;
    @(negedge clk);
    tReject();
    tWordCount();
    tNoQ();
    tTimeout();
    tStop();
    check("R4 minimum spacing", (minGap >= GAP) ? 1 : 0, 1);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule